// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a 32-bit effective address into a physical page number and access permissions. It walks a hashed page table that lives in ordinary memory. Sixteen segment registers supply a segment identifier, protection keys and two control flags. A table-base register supplies the location of the table and its size. From these the walker computes a group address and scans the group entry by entry. If the first group holds no valid match, it tries a second, complementary group.

When an entry matches, the walker decides the access rights from the entry's protection bits and a key taken from the segment. It then keeps the entry's referenced and changed bits up to date in memory by rewriting the entry's second word. It returns the page number with read and write permissions, or a fault with a syndrome word. Requests arrive one at a time over a valid/ready handshake. The walker makes at most one word access to memory per cycle, and read data comes back in the cycle after the read.

Top module: `hpt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `done`, `mem_rd` and `mem_wr` are 0. A request is taken when `req_valid` and `req_ready` are both 1 at a clock edge. While a walk is in progress `req_ready` stays 0. `done` goes to 1 for the cycle that carries the result, and the engine is then idle again.
- R2: The segment register is chosen by `req_ea[31:28]`. Its bits are: 31 direct-store, 30 privileged key, 29 user key, 28 no-execute, 23:0 segment identifier. The effective key is 1 when bit 29 is set and `req_user` is 1, or when bit 30 is set and `req_user` is 0. Otherwise the key is 0.
- R3: If the segment's direct-store bit is set, the walker reports `rsp_ds_fault`=1 with `rsp_fault`=0 and makes no memory access.
- R4: An instruction fetch (`req_fetch`=1) from a segment whose no-execute bit is set faults with syndrome 0x10000000 and makes no memory access.
- R5: The primary hash is H = ((segment id XOR `req_ea[27:12]`) AND 0x7FFFF) << 6. The group address is (base AND 0xFFFF0000) OR (H AND M), where M = (base[8:0] << 16) OR 0xFFC0. Entry i has word 0 at group+8i and word 1 at group+8i+4. A group scan reads all entries, word 0 before word 1.
- R6: An entry matches when three things hold: word 0 bit 31 is 1; word 0 bit 6 equals the pass (0 for the primary group, 1 for the secondary); and (word 0 AND 0x7FFFFFBF) equals (segment id << 7) OR (`req_ea[27:12]` >> 10).
- R7: Only when the primary group gives no usable match does the walker scan a second group. That group uses the hash (NOT H) AND 0x01FFFFC0 with the same mask and base.
- R8: With key 0 a page can always be read. It can also be written unless word 1 bits 1:0 are 11.
- R9: With key 1, word 1 bits 1:0 decode as follows: 00 gives no access, 01 and 11 give read only, and 10 gives read and write.
- R10: Several entries in one group may match. If they differ in any bit of (word 1 AND 0xFFFFF07B), that group counts as having no match. If they agree, the first matching entry is used.
- R11: On a usable match, word 1 gets bit 8 (referenced) set. On a permitted data store it also gets bit 7 (changed) set. Word 1 is written back to its own address only if its value changed. `rsp_wr_ok` is reported as 0 whenever the resulting bit 7 is 0.
- R12: The fault syndrome is 0x40000000 when neither group matches and 0x08000000 for a rights violation. A data store (`req_write`=1, `req_fetch`=0) also sets bit 0x02000000.
- R13: On a usable match `rsp_ppn` equals word 1 bits 31:12, and `rsp_rd_ok` shows read permission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_ea | input | 32 | Effective address |
| req_write | input | 1 | Data store when 1, load when 0 |
| req_fetch | input | 1 | Instruction fetch |
| req_user | input | 1 | 1 for user state, 0 for privileged state |
| seg_we | input | 1 | Segment register write strobe |
| seg_sel | input | 4 | Segment register index for the write |
| seg_wdata | input | 32 | Segment register write value |
| base_we | input | 1 | Table-base register write strobe |
| base_wdata | input | 32 | Table-base register write value |
| mem_rd | output | 1 | Memory word read strobe |
| mem_wr | output | 1 | Memory word write strobe |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after `mem_rd` |
| done | output | 1 | Result valid for one cycle |
| rsp_fault | output | 1 | Translation fault |
| rsp_ds_fault | output | 1 | Direct-store segment fault |
| rsp_syndrome | output | 32 | Fault syndrome |
| rsp_ppn | output | 20 | Physical page number |
| rsp_rd_ok | output | 1 | Read permitted |
| rsp_wr_ok | output | 1 | Write permitted |

## Verification
Two functions share the final decision cycle. In that cycle the walker writes back the updated referenced/changed bits and also registers the response. The tests provoke both at once with stores and loads to clean pages, on granted and on denied accesses. They judge the pair together, checking the written address and word against the reported permissions and syndrome. Two more functions share the scan step: latching the first match and detecting disagreement among later matches. Groups are built with matches that agree only apart from the referenced and changed bits, and with matches that disagree in the page number. The expected outcome is a hit on the first entry in the first case and a fall-through to the secondary group in the second.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_W0,
      ST_W1,
      ST_EV,
      ST_DEC
   } walk_st_e;

   // segment register contents kept by the walker (bits 27:24 are not stored)
   typedef struct packed {
      logic        ds;
      logic        sup_key;
      logic        usr_key;
      logic        noexec;
      logic [23:0] vsid;
   } seg_t;

   typedef struct packed {
      logic        fault;
      logic        ds_fault;
      logic [31:0] syndrome;
      logic [19:0] ppn;
      logic        rd_ok;
      logic        wr_ok;
   } rsp_t;

   localparam logic [31:0] SYN_MISS     = 32'h4000_0000;
   localparam logic [31:0] SYN_RIGHTS   = 32'h0800_0000;
   localparam logic [31:0] SYN_NOEXEC   = 32'h1000_0000;
   localparam logic [31:0] SYN_STORE    = 32'h0200_0000;
   localparam logic [31:0] TAG_MASK     = 32'h7FFF_FFBF;
   localparam logic [31:0] AGREE_MASK   = 32'hFFFF_F07B;
   localparam logic [31:0] REF_BIT      = 32'h0000_0100;
   localparam logic [31:0] CHG_BIT      = 32'h0000_0080;

endpackage

// File: rtl/hpt_segfile.sv
module hpt_segfile
   import hpt_pkg::*;
#(
   parameter int SEG_COUNT = 16,
   parameter int DATA_W    = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         seg_we,
   input  logic [$clog2(SEG_COUNT)-1:0] seg_sel,
   input  logic [DATA_W-1:0]            seg_wdata,
   input  logic                         base_we,
   input  logic [DATA_W-1:0]            base_wdata,
   input  logic [$clog2(SEG_COUNT)-1:0] rd_sel,
   output seg_t                         rd_seg,
   output logic [DATA_W-1:0]            base_q
);
   localparam int SEL_W = $clog2(SEG_COUNT);

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("hpt_segfile: DATA_W must be 32");
      end
      if (SEG_COUNT != (1 << SEL_W)) begin : g_bad_count
         $error("hpt_segfile: SEG_COUNT must be a power of two");
      end
   endgenerate

   seg_t              seg_q [SEG_COUNT];
   logic [SEG_COUNT-1:0] we_vec;

   generate
      for (genvar i = 0; i < SEG_COUNT; i++) begin : g_we
         assign we_vec[i] = seg_we && (seg_sel == SEL_W'(i));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < SEG_COUNT; i++) seg_q[i] <= '0;
         base_q <= '0;
      end else begin
         for (int i = 0; i < SEG_COUNT; i++) begin
            if (we_vec[i]) seg_q[i] <= {seg_wdata[31:28], seg_wdata[23:0]};
         end
         if (base_we) base_q <= base_wdata;
      end
   end

   logic unused_segbits;
   assign unused_segbits = ^seg_wdata[27:24];

   assign rd_seg = seg_q[rd_sel];

endmodule

// File: rtl/hpt_hash.sv
module hpt_hash #(
   parameter int VSID_W = 24,
   parameter int PG_W   = 16
) (
   input  logic [VSID_W-1:0] vsid,
   input  logic [PG_W-1:0]   pg,
   input  logic [31:0]       base,
   input  logic              sec,
   output logic [31:0]       group_addr,
   output logic [31:0]       tag
);
   localparam int HASH_W = 19;

   generate
      if (VSID_W != 24 || PG_W != 16) begin : g_bad_fields
         $error("hpt_hash: field widths are fixed at 24 and 16");
      end
   endgenerate

   logic [HASH_W-1:0] h_raw;
   logic [31:0]       h_pri, h_sel, h_mask;

   assign h_raw  = vsid[HASH_W-1:0] ^ {{(HASH_W-PG_W){1'b0}}, pg};
   assign h_pri  = {{(32-HASH_W-6){1'b0}}, h_raw, 6'b0};
   assign h_sel  = sec ? (~h_pri & 32'h01FF_FFC0) : h_pri;
   assign h_mask = {7'b0, base[8:0], 16'hFFC0};

   assign group_addr = {base[31:16], 16'h0} | (h_sel & h_mask);
   assign tag        = {1'b0, vsid, 7'b0} | {26'b0, pg[PG_W-1:PG_W-6]};

   logic unused_base;
   assign unused_base = ^base[15:9];

endmodule

// File: rtl/hpt_rights.sv
module hpt_rights (
   input  logic       key,
   input  logic [1:0] pp,
   input  logic       store,
   output logic       can_rd,
   output logic       can_wr,
   output logic       grant
);
   always_comb begin
      if (!key) begin
         can_rd = 1'b1;
         can_wr = (pp != 2'b11);
      end else begin
         unique case (pp)
            2'b00:   begin can_rd = 1'b0; can_wr = 1'b0; end
            2'b10:   begin can_rd = 1'b1; can_wr = 1'b1; end
            default: begin can_rd = 1'b1; can_wr = 1'b0; end
         endcase
      end
      grant = store ? can_wr : can_rd;
   end
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
   import hpt_pkg::*;
#(
   parameter int GROUP_ENTRIES = 8,
   parameter int SEG_COUNT     = 16
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   output logic        req_ready,
   input  logic [31:0] req_ea,
   input  logic        req_write,
   input  logic        req_fetch,
   input  logic        req_user,
   input  logic        seg_we,
   input  logic [3:0]  seg_sel,
   input  logic [31:0] seg_wdata,
   input  logic        base_we,
   input  logic [31:0] base_wdata,
   output logic        mem_rd,
   output logic        mem_wr,
   output logic [31:0] mem_addr,
   output logic [31:0] mem_wdata,
   input  logic [31:0] mem_rdata,
   output logic        done,
   output logic        rsp_fault,
   output logic        rsp_ds_fault,
   output logic [31:0] rsp_syndrome,
   output logic [19:0] rsp_ppn,
   output logic        rsp_rd_ok,
   output logic        rsp_wr_ok
);
   localparam int IDX_W = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP_ENTRIES - 1);

   generate
      if (GROUP_ENTRIES < 1 || GROUP_ENTRIES > 8 ||
          (GROUP_ENTRIES & (GROUP_ENTRIES - 1)) != 0) begin : g_bad_group
         $error("hpt_walker: GROUP_ENTRIES must be a power of two from 1 to 8");
      end
      if (SEG_COUNT != 16) begin : g_bad_seg
         $error("hpt_walker: four address bits select the segment, SEG_COUNT must be 16");
      end
   endgenerate

   // configuration registers
   seg_t        seg_rd;
   logic [31:0] base_q;

   hpt_segfile #(.SEG_COUNT(SEG_COUNT), .DATA_W(32)) u_segs (
      .clk        (clk),
      .rst_n      (rst_n),
      .seg_we     (seg_we),
      .seg_sel    (seg_sel),
      .seg_wdata  (seg_wdata),
      .base_we    (base_we),
      .base_wdata (base_wdata),
      .rd_sel     (req_ea[31:28]),
      .rd_seg     (seg_rd),
      .base_q     (base_q)
   );

   // walk state
   walk_st_e         st;
   seg_t             sr_q;
   logic [15:0]      pg_q;
   logic             store_q, user_q, pass_q;
   logic [IDX_W-1:0] idx_q;
   logic [31:0]      w0_q, keep_q, keep_addr_q;
   logic             found_q, clash_q;
   rsp_t             rsp_q;

   logic [31:0] group_addr, tag, entry_addr;
   logic        key, can_rd, can_wr, grant, hit_now, use_hit, need_wb;
   logic [31:0] new_w1;

   hpt_hash u_hash (
      .vsid       (sr_q.vsid),
      .pg         (pg_q),
      .base       (base_q),
      .sec        (pass_q),
      .group_addr (group_addr),
      .tag        (tag)
   );

   assign key = (sr_q.usr_key & user_q) | (sr_q.sup_key & ~user_q);

   hpt_rights u_rights (
      .key    (key),
      .pp     (keep_q[1:0]),
      .store  (store_q),
      .can_rd (can_rd),
      .can_wr (can_wr),
      .grant  (grant)
   );

   assign entry_addr = group_addr + (32'(idx_q) << 3);
   assign hit_now    = w0_q[31] && (w0_q[6] == pass_q) && ((w0_q & TAG_MASK) == tag);
   assign use_hit    = found_q && !clash_q;
   assign new_w1     = keep_q | REF_BIT | ((grant && store_q) ? CHG_BIT : 32'h0);
   assign need_wb    = (new_w1 != keep_q);

   // memory port
   always_comb begin
      mem_rd    = (st == ST_W0) || (st == ST_W1);
      mem_wr    = (st == ST_DEC) && use_hit && need_wb;
      mem_wdata = new_w1;
      unique case (st)
         ST_W1:   mem_addr = entry_addr + 32'd4;
         ST_DEC:  mem_addr = keep_addr_q + 32'd4;
         default: mem_addr = entry_addr;
      endcase
   end

   assign req_ready = (st == ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st          <= ST_IDLE;
         sr_q        <= '0;
         pg_q        <= '0;
         store_q     <= 1'b0;
         user_q      <= 1'b0;
         pass_q      <= 1'b0;
         idx_q       <= '0;
         w0_q        <= '0;
         keep_q      <= '0;
         keep_addr_q <= '0;
         found_q     <= 1'b0;
         clash_q     <= 1'b0;
         rsp_q       <= '0;
         done        <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (st)
            ST_IDLE: if (req_valid) begin
               sr_q    <= seg_rd;
               pg_q    <= req_ea[27:12];
               store_q <= req_write & ~req_fetch;
               user_q  <= req_user;
               pass_q  <= 1'b0;
               idx_q   <= '0;
               found_q <= 1'b0;
               clash_q <= 1'b0;
               if (seg_rd.ds) begin
                  done  <= 1'b1;
                  rsp_q <= '{fault: 1'b0, ds_fault: 1'b1, syndrome: 32'h0,
                             ppn: 20'h0, rd_ok: 1'b0, wr_ok: 1'b0};
               end else if (req_fetch && seg_rd.noexec) begin
                  done  <= 1'b1;
                  rsp_q <= '{fault: 1'b1, ds_fault: 1'b0, syndrome: SYN_NOEXEC,
                             ppn: 20'h0, rd_ok: 1'b0, wr_ok: 1'b0};
               end else begin
                  st <= ST_W0;
               end
            end
            ST_W0: st <= ST_W1;
            ST_W1: begin
               w0_q <= mem_rdata;
               st   <= ST_EV;
            end
            ST_EV: begin
               if (hit_now) begin
                  if (!found_q) begin
                     found_q     <= 1'b1;
                     keep_q      <= mem_rdata;
                     keep_addr_q <= entry_addr;
                  end else if (((keep_q ^ mem_rdata) & AGREE_MASK) != 32'h0) begin
                     clash_q <= 1'b1;
                  end
               end
               if (idx_q == LAST_IDX) begin
                  st <= ST_DEC;
               end else begin
                  idx_q <= idx_q + 1'b1;
                  st    <= ST_W0;
               end
            end
            ST_DEC: begin
               if (use_hit) begin
                  done  <= 1'b1;
                  st    <= ST_IDLE;
                  rsp_q <= '{fault: ~grant, ds_fault: 1'b0,
                             syndrome: grant ? 32'h0 : (SYN_RIGHTS | (store_q ? SYN_STORE : 32'h0)),
                             ppn: keep_q[31:12], rd_ok: can_rd, wr_ok: can_wr & new_w1[7]};
               end else if (!pass_q) begin
                  pass_q  <= 1'b1;
                  idx_q   <= '0;
                  found_q <= 1'b0;
                  clash_q <= 1'b0;
                  st      <= ST_W0;
               end else begin
                  done  <= 1'b1;
                  st    <= ST_IDLE;
                  rsp_q <= '{fault: 1'b1, ds_fault: 1'b0,
                             syndrome: SYN_MISS | (store_q ? SYN_STORE : 32'h0),
                             ppn: 20'h0, rd_ok: 1'b0, wr_ok: 1'b0};
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign rsp_fault    = rsp_q.fault;
   assign rsp_ds_fault = rsp_q.ds_fault;
   assign rsp_syndrome = rsp_q.syndrome;
   assign rsp_ppn      = rsp_q.ppn;
   assign rsp_rd_ok    = rsp_q.rd_ok;
   assign rsp_wr_ok    = rsp_q.wr_ok;

   // R1: a taken request either finishes at once or holds the engine busy
   a_r1_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (done || !req_ready));

   // R1: the engine is idle whenever a result is presented
   a_r1_idle_on_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> req_ready);

   // R5: never more than one word access per cycle, always word aligned
   a_r5_one_access: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));
   a_r5_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> (mem_addr[1:0] == 2'b00));

   // R11: every write-back carries the referenced bit
   a_r11_ref_in_wb: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> mem_wdata[8]);

   // R8 / R9: write permission never appears without read permission
   a_r8_wr_needs_rd: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsp_wr_ok) |-> rsp_rd_ok);

   // R3: a direct-store result is not also a translation fault
   a_r3_ds_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rsp_ds_fault) |-> (!rsp_fault && !rsp_rd_ok));

endmodule

// File: tb/hpt_walker_test.sv
module hpt_walker_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_ea = '0;
   logic        req_write = 1'b0;
   logic        req_fetch = 1'b0;
   logic        req_user = 1'b0;
   logic        seg_we = 1'b0;
   logic [3:0]  seg_sel = '0;
   logic [31:0] seg_wdata = '0;
   logic        base_we = 1'b0;
   logic [31:0] base_wdata = '0;
   logic        mem_rd, mem_wr;
   logic [31:0] mem_addr, mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic        done, rsp_fault, rsp_ds_fault, rsp_rd_ok, rsp_wr_ok;
   logic [31:0] rsp_syndrome;
   logic [19:0] rsp_ppn;

   always #5 clk = ~clk;

   hpt_walker uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_ea(req_ea),
      .req_write(req_write), .req_fetch(req_fetch), .req_user(req_user),
      .seg_we(seg_we), .seg_sel(seg_sel), .seg_wdata(seg_wdata),
      .base_we(base_we), .base_wdata(base_wdata),
      .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .done(done), .rsp_fault(rsp_fault), .rsp_ds_fault(rsp_ds_fault),
      .rsp_syndrome(rsp_syndrome), .rsp_ppn(rsp_ppn),
      .rsp_rd_ok(rsp_rd_ok), .rsp_wr_ok(rsp_wr_ok)
   );

   // memory model: one-cycle read latency
   logic [31:0] mem [logic [31:0]];
   int          rd_total = 0, wr_total = 0;
   logic [31:0] last_wa = '0, last_wd = '0;

   always @(posedge clk) begin
      if (mem_rd) begin
         mem_rdata <= mem.exists(mem_addr) ? mem[mem_addr] : 32'h0;
         rd_total++;
      end
      if (mem_wr) begin
         mem[mem_addr] = mem_wdata;
         wr_total++;
         last_wa = mem_addr;
         last_wd = mem_wdata;
      end
   end

   int n_tests = 0, n_fail = 0;
   int g_rd, g_wr;
   logic rdy_after;

   initial begin
      repeat (100000) @(posedge clk);
      $display("FAIL R1 watchdog expired: got running expected finished");
      $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
      $finish;
   end

   task automatic chk(input string tag, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [15:0] pg,
                                       input bit sec, input logic [31:0] base);
      logic [31:0] h;
      h = ((32'(vsid) ^ 32'(pg)) & 32'h0007_FFFF) << 6;
      if (sec) h = ~h & 32'h01FF_FFC0;
      return (base & 32'hFFFF_0000) | (h & (((base & 32'h1FF) << 16) | 32'hFFC0));
   endfunction

   function automatic logic [31:0] tag0(input logic [23:0] vsid, input logic [15:0] pg,
                                        input bit sec);
      return 32'h8000_0000 | (32'(vsid) << 7) | (32'(pg) >> 10) | (sec ? 32'h40 : 32'h0);
   endfunction

   task automatic put(input logic [31:0] g, input int i, input logic [31:0] w0,
                      input logic [31:0] w1);
      mem[g + 32'(i * 8)]     = w0;
      mem[g + 32'(i * 8) + 4] = w1;
   endtask

   task automatic set_seg(input logic [3:0] idx, input logic [31:0] v);
      @(negedge clk);
      seg_we = 1'b1; seg_sel = idx; seg_wdata = v;
      @(negedge clk);
      seg_we = 1'b0;
   endtask

   task automatic set_base(input logic [31:0] v);
      @(negedge clk);
      base_we = 1'b1; base_wdata = v;
      @(negedge clk);
      base_we = 1'b0;
   endtask

   task automatic run(input logic [31:0] ea, input bit wr, input bit fe, input bit usr);
      int rd0, wr0, guard;
      @(negedge clk);
      rd0 = rd_total; wr0 = wr_total;
      req_ea = ea; req_write = wr; req_fetch = fe; req_user = usr; req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      rdy_after = req_ready;
      guard = 0;
      while (!done && guard < 300) begin
         @(negedge clk);
         guard++;
      end
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL R1 request never completed: got done=0 expected done=1");
      end
      g_rd = rd_total - rd0;
      g_wr = wr_total - wr0;
   endtask

   task automatic t_reset;
      chk("R1", "ready after reset", 32'(req_ready), 32'd1);
      chk("R1", "done after reset", 32'(done), 32'd0);
      chk("R1", "memory idle after reset", 32'({mem_rd, mem_wr}), 32'd0);
   endtask

   task automatic t_direct_store;
      set_seg(4'd1, 32'h8000_0123);
      run(32'h1000_0000, 1'b0, 1'b0, 1'b0);
      chk("R3", "ds flag", 32'(rsp_ds_fault), 32'd1);
      chk("R3", "fault flag", 32'(rsp_fault), 32'd0);
      chk("R3", "memory accesses", 32'(g_rd + g_wr), 32'd0);
   endtask

   task automatic t_noexec;
      set_seg(4'd2, 32'h1000_0055);
      run(32'h2000_0000, 1'b0, 1'b1, 1'b0);
      chk("R4", "fetch fault", 32'(rsp_fault), 32'd1);
      chk("R4", "fetch syndrome", rsp_syndrome, 32'h1000_0000);
      chk("R4", "memory accesses", 32'(g_rd + g_wr), 32'd0);
      // a data load in the same segment walks both groups and misses
      run(32'h2000_0000, 1'b0, 1'b0, 1'b0);
      chk("R12", "load miss syndrome", rsp_syndrome, 32'h4000_0000);
      chk("R7", "reads for two groups", 32'(g_rd), 32'd32);
   endtask

   task automatic t_primary;
      logic [31:0] g;
      set_seg(4'd3, 32'h0000_0123);
      g = grp(24'h123, 16'h0045, 1'b0, 32'h0);
      put(g, 0, tag0(24'h123, 16'h0045, 1'b0) & 32'h7FFF_FFFF, 32'h1111_1002);
      put(g, 1, tag0(24'h124, 16'h0045, 1'b0), 32'h2222_2002);
      put(g, 2, tag0(24'h123, 16'h0045, 1'b0), 32'hABCD_E002);
      run(32'h3004_5000, 1'b0, 1'b0, 1'b0);
      chk("R1", "ready low during walk", 32'(rdy_after), 32'd0);
      chk("R13", "ppn", 32'(rsp_ppn), 32'hABCDE);
      chk("R6", "no fault", 32'(rsp_fault), 32'd0);
      chk("R5", "reads for one group", 32'(g_rd), 32'd16);
      chk("R8", "read ok key0", 32'(rsp_rd_ok), 32'd1);
      chk("R11", "write withheld while clean", 32'(rsp_wr_ok), 32'd0);
      chk("R11", "one write-back", 32'(g_wr), 32'd1);
      chk("R5", "write-back address", last_wa, g + 32'd20);
      chk("R11", "referenced set", last_wd, 32'hABCD_E102);
      run(32'h3004_5000, 1'b1, 1'b0, 1'b0);
      chk("R11", "changed set on store", last_wd, 32'hABCD_E182);
      chk("R8", "store writable key0", 32'(rsp_wr_ok), 32'd1);
      run(32'h3004_5000, 1'b0, 1'b0, 1'b0);
      chk("R11", "no write-back when unchanged", 32'(g_wr), 32'd0);
      chk("R11", "write ok once changed", 32'(rsp_wr_ok), 32'd1);
   endtask

   task automatic t_secondary;
      logic [31:0] g1, g2;
      set_seg(4'd4, 32'h2000_0777);
      g1 = grp(24'h777, 16'h0012, 1'b0, 32'h0);
      g2 = grp(24'h777, 16'h0012, 1'b1, 32'h0);
      put(g1, 0, tag0(24'h777, 16'h0012, 1'b1), 32'h1111_1002);
      put(g2, 5, tag0(24'h777, 16'h0012, 1'b1), 32'h2222_2002);
      run(32'h4001_2000, 1'b1, 1'b0, 1'b1);
      chk("R7", "secondary ppn", 32'(rsp_ppn), 32'h22222);
      chk("R6", "pass bit respected", 32'(rsp_fault), 32'd0);
      chk("R9", "key1 pp10 writable", 32'(rsp_wr_ok), 32'd1);
      chk("R7", "reads", 32'(g_rd), 32'd32);
      chk("R7", "write-back address", last_wa, g2 + 32'd44);
      chk("R11", "write-back data", last_wd, 32'h2222_2182);
   endtask

   task automatic t_key1;
      set_seg(4'd6, 32'h2000_0066);
      put(grp(24'h66, 16'h0, 1'b0, 32'h0), 0, tag0(24'h66, 16'h0, 1'b0), 32'h3333_3001);
      run(32'h6000_0000, 1'b1, 1'b0, 1'b1);
      chk("R12", "store rights syndrome", rsp_syndrome, 32'h0A00_0000);
      chk("R9", "pp01 readable", 32'(rsp_rd_ok), 32'd1);
      chk("R9", "pp01 not writable", 32'(rsp_wr_ok), 32'd0);
      chk("R11", "referenced set on denial", last_wd, 32'h3333_3101);
      run(32'h6000_0000, 1'b0, 1'b0, 1'b1);
      chk("R9", "pp01 load passes", 32'(rsp_fault), 32'd0);
      chk("R11", "no second write-back", 32'(g_wr), 32'd0);
      set_seg(4'd7, 32'h2000_0099);
      put(grp(24'h99, 16'h0, 1'b0, 32'h0), 0, tag0(24'h99, 16'h0, 1'b0), 32'h4444_4000);
      run(32'h7000_0000, 1'b0, 1'b0, 1'b1);
      chk("R12", "load rights syndrome", rsp_syndrome, 32'h0800_0000);
      chk("R9", "pp00 not readable", 32'(rsp_rd_ok), 32'd0);
   endtask

   task automatic t_key_select;
      set_seg(4'd8, 32'h4000_00AA);
      put(grp(24'hAA, 16'h0, 1'b0, 32'h0), 0, tag0(24'hAA, 16'h0, 1'b0), 32'h5A5A_5000);
      run(32'h8000_0000, 1'b0, 1'b0, 1'b1);
      chk("R2", "privileged key ignored in user state", 32'(rsp_fault), 32'd0);
      run(32'h8000_0000, 1'b0, 1'b0, 1'b0);
      chk("R2", "privileged key used in privileged state", rsp_syndrome, 32'h0800_0000);
      set_seg(4'd9, 32'h0000_00BB);
      put(grp(24'hBB, 16'h0, 1'b0, 32'h0), 0, tag0(24'hBB, 16'h0, 1'b0), 32'h5555_5003);
      run(32'h9000_0000, 1'b1, 1'b0, 1'b0);
      chk("R8", "key0 pp11 store denied", rsp_syndrome, 32'h0A00_0000);
      chk("R8", "key0 pp11 readable", 32'(rsp_rd_ok), 32'd1);
   endtask

   task automatic t_clash;
      logic [31:0] g;
      set_seg(4'd10, 32'h0000_0CCC);
      g = grp(24'hCCC, 16'h0, 1'b0, 32'h0);
      put(g, 1, tag0(24'hCCC, 16'h0, 1'b0), 32'h6666_6002);
      put(g, 4, tag0(24'hCCC, 16'h0, 1'b0), 32'h7777_7002);
      run(32'hA000_0000, 1'b0, 1'b1, 1'b0);
      chk("R10", "disagreeing matches miss", rsp_syndrome, 32'h4000_0000);
      chk("R10", "no write-back", 32'(g_wr), 32'd0);
      set_seg(4'd11, 32'h0000_00EE);
      g = grp(24'hEE, 16'h0, 1'b0, 32'h0);
      put(g, 3, tag0(24'hEE, 16'h0, 1'b0), 32'h8888_8002);
      put(g, 6, tag0(24'hEE, 16'h0, 1'b0), 32'h8888_8182);
      run(32'hB000_0000, 1'b0, 1'b0, 1'b0);
      chk("R10", "agreeing matches hit", 32'(rsp_ppn), 32'h88888);
      chk("R10", "first match written", last_wa, g + 32'd28);
      chk("R10", "first match data", last_wd, 32'h8888_8102);
   endtask

   task automatic t_miss_store;
      set_seg(4'd12, 32'h0000_0DDD);
      run(32'hC000_0000, 1'b1, 1'b0, 1'b0);
      chk("R12", "store miss syndrome", rsp_syndrome, 32'h4200_0000);
      chk("R12", "store miss fault", 32'(rsp_fault), 32'd1);
   endtask

   task automatic t_table_size;
      logic [31:0] g;
      set_base(32'h0010_0001);
      set_seg(4'd13, 32'h0000_0400);
      g = grp(24'h400, 16'h0, 1'b0, 32'h0010_0001);
      chk("R5", "bench group with size bit", g, 32'h0011_0000);
      put(32'h0010_0000, 0, tag0(24'h400, 16'h0, 1'b0), 32'hAAAA_A002);
      put(g, 0, tag0(24'h400, 16'h0, 1'b0), 32'h9999_9002);
      run(32'hD000_0000, 1'b0, 1'b0, 1'b0);
      chk("R5", "table size widens mask", 32'(rsp_ppn), 32'h99999);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_direct_store();
      t_noexec();
      t_primary();
      t_secondary();
      t_key1();
      t_key_select();
      t_clash();
      t_miss_store();
      t_table_size();
      repeat (2) @(negedge clk);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule